// File: doc/BRIEF.md
# ADC Code to ASCII Millivolt Formatter

This block turns one unsigned sample from a unipolar 3 V converter into a printable decimal string in millivolts. It uses integer arithmetic only. The code is scaled to microvolts with round-to-nearest. The division by a power of two is done as a bit shift. The microvolt integer is then turned into decimal digits by a sequential shift-and-add-three loop. A point is placed so that exactly three fractional digits follow it.

A producer offers a 14-bit code with a valid/ready handshake. While a conversion is in flight the block drops ready, and it accepts nothing. When the string is complete, the character buffer and the character count are updated together and a one-cycle done strobe marks them. Both outputs then hold until the next strobe. A conversion takes a few dozen clock cycles, far more than enough for ten thousand samples per second at any usual clock rate.

Top module: `adc_mv_formatter`

## Requirements
- R1: After reset, in_ready is 1, out_done is 0, out_len is 0 and every byte of out_chars is 0.
- R2: The microvolt value is floor((code × 6,000,000 + 16,384) / 32,768), which is code × 3,000,000 / 2^14 rounded to nearest.
- R3: The string has exactly three digits after the point. The point is ASCII 0x2E and sits at character index out_len−4.
- R4: Values below 1000 µV are zero-padded to four digits, so a digit always precedes the point (code 0 gives "0.000").
- R5: out_len equals the number of integer digits shown plus one. It lies between 5 and 8, and full scale (code 16383) gives "2999.817" with length 8.
- R6: Character index i sits in out_chars[8i+7:8i], with index 0 the leftmost character. Digits are ASCII 0x30 plus the digit value. Every byte at index out_len or above is 0.
- R7: in_ready is 1 only while idle. A sample is taken on a cycle where in_valid and in_ready are both 1. in_valid and in_code have no effect while in_ready is 0.
- R8: out_done is a single-cycle pulse. out_chars and out_len change only together with it and hold their values between pulses.
- R9: out_done arrives no more than 32 cycles after the accepting cycle, and in_ready is 1 again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_code | input | 14 | Unsigned converter code |
| out_chars | output | 64 | Character buffer, index 0 in the low byte |
| out_len | output | 4 | Number of valid characters |
| out_done | output | 1 | One-cycle strobe when buffer and length are new |

## Verification
Any wrong internal state shows up in the first string produced after it arises. A bad digit-loop step or a wrong correction corrupts one or more digit characters. A wrong leading-digit count moves the point or changes out_len. A scaling error shifts the least significant digits, and the rounding edge cases expose it. A stuck control state shows within the next 32 cycles, as a missing done or as ready staying low. A sample taken while busy shows as a result that does not belong to the code that was accepted.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CONV = 2'd2
  } mvf_state_e;

  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_POINT = 8'h2E;

endpackage

// File: rtl/mvf_scale.sv
// Microvolt scaling with round-to-nearest:
// (code * 2*FS + 2^CODE_W) >> (CODE_W+1)
module mvf_scale #(
  parameter int CODE_W = 14,
  parameter int FS_UV  = 3000000,
  parameter int UV_W   = 22
) (
  input  logic [CODE_W-1:0] code,
  output logic [UV_W-1:0]   uv
);
  localparam int PROD_W = CODE_W + $clog2(2*FS_UV + 1) + 1;
  localparam logic [PROD_W-1:0] MULT = PROD_W'(2*FS_UV);
  localparam logic [PROD_W-1:0] RND  = PROD_W'(1) << CODE_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(code) * MULT + RND;
    uv   = prod[CODE_W+1 +: UV_W];
  end
endmodule

// File: rtl/mvf_dabble.sv
// Sequential binary to BCD conversion, one bit per cycle.
module mvf_dabble #(
  parameter int BIN_W = 22,
  parameter int NDIG  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BIN_W-1:0]  bin,
  output logic              busy,
  output logic [4*NDIG-1:0] bcd
);
  localparam int BCD_W = 4 * NDIG;
  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0] bin_q, bin_d;
  logic [BCD_W-1:0] bcd_q, bcd_d, adj;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  for (genvar g = 0; g < NDIG; g++) begin : g_adj
    assign adj[g*4 +: 4] = (bcd_q[g*4 +: 4] >= 4'd5) ?
                           bcd_q[g*4 +: 4] + 4'd3 : bcd_q[g*4 +: 4];
  end

  assign busy = (cnt_q != '0);
  assign en   = start | busy;

  always_comb begin
    bin_d = bin_q;
    bcd_d = bcd_q;
    cnt_d = cnt_q;
    if (start) begin
      bin_d = bin;
      bcd_d = '0;
      cnt_d = CNT_W'(BIN_W);
    end else if (busy) begin
      bcd_d = {adj[BCD_W-2:0], bin_q[BIN_W-1]};
      bin_d = {bin_q[BIN_W-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      bcd_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      bin_q <= bin_d;
      bcd_q <= bcd_d;
      cnt_q <= cnt_d;
    end
  end

  assign bcd = bcd_q;
endmodule

// File: rtl/mvf_ascii.sv
// BCD digits to ASCII with a point before the last FRAC digits.
module mvf_ascii #(
  parameter int NDIG  = 7,
  parameter int FRAC  = 3,
  parameter int NCH   = 8,
  parameter int LEN_W = 4
) (
  input  logic [4*NDIG-1:0] bcd,
  output logic [8*NCH-1:0]  chars,
  output logic [LEN_W-1:0]  len
);
  import mvf_pkg::*;

  int nd;
  int k;

  always_comb begin
    nd = FRAC + 1;
    for (int i = FRAC + 1; i < NDIG; i++) begin
      if (bcd[i*4 +: 4] != 4'd0) nd = i + 1;
    end
    chars = '0;
    for (int p = 0; p < NCH; p++) begin
      k = 0;
      if (p < nd - FRAC) begin
        k = nd - 1 - p;
        chars[p*8 +: 8] = CH_ZERO | {4'd0, bcd[k*4 +: 4]};
      end else if (p == nd - FRAC) begin
        chars[p*8 +: 8] = CH_POINT;
      end else if (p <= nd) begin
        k = nd - p;
        chars[p*8 +: 8] = CH_ZERO | {4'd0, bcd[k*4 +: 4]};
      end
    end
    len = LEN_W'(nd + 1);
  end
endmodule

// File: rtl/adc_mv_formatter.sv
module adc_mv_formatter #(
  parameter int CODE_W   = 14,
  parameter int FS_UV    = 3000000,
  parameter int NDIG     = 7,
  parameter int FRAC_DIG = 3,
  parameter int NCH      = NDIG + 1,
  parameter int LEN_W    = $clog2(NCH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CODE_W-1:0]   in_code,
  output logic [8*NCH-1:0]    out_chars,
  output logic [LEN_W-1:0]    out_len,
  output logic                out_done
);
  import mvf_pkg::*;

  localparam int UV_W = $clog2(FS_UV + 1);

  mvf_state_e           state_q, state_d;
  logic [UV_W-1:0]      uv_q, uv_s;
  logic [8*NCH-1:0]     chars_q, chars_s;
  logic [LEN_W-1:0]     len_q, len_s;
  logic                 done_q, done_d;
  logic                 accept, finish, dab_start, dab_busy;
  logic [4*NDIG-1:0]    bcd;

  mvf_scale #(.CODE_W(CODE_W), .FS_UV(FS_UV), .UV_W(UV_W)) i_scale (
    .code (in_code),
    .uv   (uv_s)
  );

  mvf_dabble #(.BIN_W(UV_W), .NDIG(NDIG)) i_dabble (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dab_start),
    .bin   (uv_q),
    .busy  (dab_busy),
    .bcd   (bcd)
  );

  mvf_ascii #(.NDIG(NDIG), .FRAC(FRAC_DIG), .NCH(NCH), .LEN_W(LEN_W)) i_ascii (
    .bcd   (bcd),
    .chars (chars_s),
    .len   (len_s)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_ready & in_valid;
  assign dab_start = (state_q == ST_LOAD);
  assign finish    = (state_q == ST_CONV) & ~dab_busy;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_CONV;
      ST_CONV: if (finish) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= '0;
    else if (accept) uv_q <= uv_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chars_q <= '0;
      len_q   <= '0;
    end else if (finish) begin
      chars_q <= chars_s;
      len_q   <= len_s;
    end
  end

  assign out_chars = chars_q;
  assign out_len   = len_q;
  assign out_done  = done_q;
endmodule

// File: rtl/mvf_checks.sv
module mvf_checks #(
  parameter int NCH     = 8,
  parameter int LEN_W   = 4,
  parameter int LAT_MAX = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [8*NCH-1:0] out_chars,
  input logic [LEN_W-1:0] out_len,
  input logic             out_done
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (in_ready) busy_cnt <= '0;
    else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_chars) && $stable(out_len)));

  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_len >= LEN_W'(5) && out_len <= LEN_W'(NCH)));

  a_r3_point_place: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_chars[(int'(out_len) - 4) * 8 +: 8] == 8'h2E));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);

  a_r9_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 8'(LAT_MAX));
endmodule

bind adc_mv_formatter mvf_checks #(.NCH(NCH), .LEN_W(LEN_W)) i_mvf_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_chars (out_chars),
  .out_len   (out_len),
  .out_done  (out_done)
);

// File: tb/test_adc_mv_formatter.sv
`timescale 1ns/1ps
module test_adc_mv_formatter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [13:0] in_code;
  logic [63:0] out_chars;
  logic [3:0]  out_len;
  logic        out_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  adc_mv_formatter i_adc_mv_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_chars(out_chars), .out_len(out_len),
    .out_done(out_done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R2: rounded microvolts; R3/R4/R5/R6 string layout
  function automatic longint exp_uv(input int code);
    return (longint'(code) * 64'd6000000 + 64'd16384) >> 15;
  endfunction

  function automatic void exp_fmt(input int code, output logic [63:0] ch,
                                  output int len);
    longint uv, t, pw;
    int nd, k;
    uv = exp_uv(code);
    nd = 1;
    t = uv;
    while (t >= 10) begin t = t / 10; nd++; end
    if (nd < 4) nd = 4;
    len = nd + 1;
    ch = '0;
    for (int p = 0; p < len; p++) begin
      if (p == nd - 3) ch[p*8 +: 8] = 8'h2E;
      else begin
        k = (p < nd - 3) ? nd - 1 - p : nd - p;
        pw = 1;
        for (int j = 0; j < k; j++) pw = pw * 10;
        ch[p*8 +: 8] = 8'h30 + 8'((uv / pw) % 10);
      end
    end
  endfunction

  // Offer a code, optionally hold junk on in_valid/in_code while busy (R7)
  task automatic convert(input int code, input bit junk, input string req);
    logic [63:0] ech, prev_ch;
    int elen, lat;
    bit seen;
    exp_fmt(code, ech, elen);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_code  = 14'(code);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7", "ready low after accept", 64'(in_ready), 64'd0);
    in_valid = junk;
    in_code  = 14'(code ^ 16'h2A5B);
    seen = 0;
    lat  = 1;
    while (!seen && lat <= 40) begin
      if (out_done) seen = 1;
      else begin
        if (in_ready) in_valid = 1'b0;
        in_code = 14'($urandom);
        @(negedge clk);
        lat++;
      end
    end
    in_valid = 1'b0;
    chk(seen && lat <= 33, "R9", "done within bound", 64'(lat), 64'd33);
    chk(in_ready == 1'b1, "R9", "ready with done", 64'(in_ready), 64'd1);
    chk(out_chars == ech, req, $sformatf("chars code %0d", code), out_chars, ech);
    chk(int'(out_len) == elen, "R5", $sformatf("len code %0d", code),
        64'(out_len), 64'(elen));
    prev_ch = out_chars;
    @(negedge clk);
    chk(out_done == 1'b0, "R8", "single-cycle done", 64'(out_done), 64'd0);
    chk(out_chars == prev_ch, "R8", "chars held", out_chars, prev_ch);
  endtask

  initial begin
    logic [63:0] e;
    int el;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);
    chk(out_done == 1'b0, "R1", "done after reset", 64'(out_done), 64'd0);
    chk(out_len == 4'd0, "R1", "len after reset", 64'(out_len), 64'd0);
    chk(out_chars == 64'd0, "R1", "chars after reset", out_chars, 64'd0);

    // R4: zero padding, "0.000"
    convert(0, 0, "R4");
    exp_fmt(0, e, el);
    chk(e == 64'h30_30_30_2E_30 && el == 5, "R4", "bench model 0.000", e, 64'h303030_2E30);
    convert(1, 0, "R4");
    convert(5, 0, "R2");
    convert(6, 0, "R2");
    // R5: full scale "2999.817" length 8
    convert(16383, 0, "R5");
    exp_fmt(16383, e, el);
    chk(e == 64'h37_31_38_2E_39_39_39_32, "R5", "bench model full scale",
        e, 64'h3731382E39393932);
    // R3/R6 around digit-count transitions (9999/10000 uV, 99999/100000 uV)
    for (int c = 53; c <= 56; c++) convert(c, 0, "R3");
    for (int c = 544; c <= 548; c++) convert(c, 0, "R6");
    for (int c = 5459; c <= 5464; c++) convert(c, 0, "R6");
    // R7: junk on in_valid/in_code while busy has no effect
    convert(1234, 1, "R7");
    convert(16382, 1, "R7");
    // R2 random mix
    for (int i = 0; i < 300; i++) convert(int'($urandom_range(0, 16383)), i[0], "R2");
    // R8: outputs stay put with no new sample
    e = out_chars;
    repeat (10) @(negedge clk);
    chk(out_chars == e && out_done == 1'b0, "R8", "idle hold", out_chars, e);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule